// File: doc/BRIEF.md
# Dual-Rate Timing Enable Generator

This block derives every internal timing enable of a small 8-bit controller core from one oscillator clock. It produces a per-state tick for the CPU sequencer, a matching tick for the peripheral time base (timers, serial baud logic) and a machine-cycle strobe. All three are single-cycle enables in the oscillator domain, so the rest of the core runs on the oscillator clock and simply qualifies its registers with them.

A single-bit rate select lives in a clock-control register on a plain special-function-register bus, which has an address, write data, a write strobe and registered read data. With the bit clear, the core runs at standard rate: one state per two oscillator periods, so twelve oscillator periods per six-state machine cycle. With the bit set, it runs at double rate: one state per oscillator period, so six periods per machine cycle. Peripherals see the same change, so timer and baud rates double.

A new setting is held until a divide-by-two phase pair completes, and only then applied. No tick is lost, split or duplicated across the switch, and the machine-cycle strobe keeps its spacing of six ticks.

Top module: `dual_rate_timebase`

## Requirements
- R1: The control register answers at SFR address 0x8F. Bit 0 is the rate select (0 = standard, 1 = double). A read returns, one clock after the address is presented, the last value written to that bit.
- R2: Synchronous active-high reset clears the rate select, the divide phase and the state counter. While in reset and after it, all enables are low until counting resumes, and a read of 0x8F returns 0.
- R3: At standard rate, `state_tick` pulses once every 2 oscillator cycles (12 pulses in any 24-cycle window).
- R4: At double rate, `state_tick` is high on every oscillator cycle.
- R5: `mcycle_strobe` is high only together with `state_tick`, on every sixth tick. That gives 12 cycles per machine cycle at standard rate and 6 at double rate.
- R6: `periph_tick` is identical to `state_tick` on every cycle.
- R7: Bits 7 to 1 of the control register ignore writes and always read 0. A write of data d to 0x8F reads back as d & 1.
- R8: A read at any address other than 0x8F returns 0. A write to any other address changes neither the register nor the tick rate.
- R9: A rate change is applied only at the end of a complete divide-by-two phase pair. The spacing between consecutive ticks is always 1 or 2 cycles, and strobes stay exactly six ticks apart across any switch.
- R10: A write that changes the rate takes effect at the outputs within 3 clock edges of the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| sfr_addr | input | 8 | SFR bus address |
| sfr_wdata | input | 8 | SFR bus write data |
| sfr_we | input | 1 | SFR bus write strobe |
| sfr_rdata | output | 8 | SFR bus read data, registered |
| state_tick | output | 1 | CPU state enable |
| periph_tick | output | 1 | Peripheral time-base enable |
| mcycle_strobe | output | 1 | Last-state-of-machine-cycle enable |

## Verification
A wrong divide phase or rate bit appears within two or three cycles as a tick spacing other than the one the mode calls for. A switch applied mid-phase would likewise show up as a split or doubled interval next to the write. A state counter that drifts or skips shows at the next machine-cycle strobe, at most twelve cycles later, as a strobe that is not six ticks after the previous one. Register decode faults appear one cycle after the read address is presented, as a nonzero reserved bit or a nonzero value at a foreign address.

// File: rtl/drt_pkg.sv
package drt_pkg;
  typedef enum logic {
    RATE_STD  = 1'b0,
    RATE_FAST = 1'b1
  } rate_e;

  // number of oscillator cycles per internal state at a given rate
  function automatic int unsigned osc_per_state(input rate_e r);
    return (r == RATE_FAST) ? 1 : 2;
  endfunction
endpackage

// File: rtl/drt_ctrl_sfr.sv
module drt_ctrl_sfr #(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h8F,
  parameter int          SEL_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              sfr_we,
  output logic [DATA_W-1:0] sfr_rdata,
  output drt_pkg::rate_e    rate_req
);
  import drt_pkg::*;

  logic hit;
  assign hit = (sfr_addr == CTRL_ADDR);

  rate_e sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= RATE_STD;
    end else if (sfr_we && hit) begin
      sel_q <= rate_e'(sfr_wdata[SEL_BIT]);
    end
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (hit) begin
      rd_next[SEL_BIT] = sel_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sfr_rdata <= '0;
    end else begin
      sfr_rdata <= rd_next;
    end
  end

  assign rate_req = sel_q;
endmodule

// File: rtl/drt_rate_phase.sv
module drt_rate_phase (
  input  logic           clk,
  input  logic           rst,
  input  drt_pkg::rate_e rate_req,
  output logic           phase,
  output drt_pkg::rate_e rate_eff,
  output logic           int_tick
);
  import drt_pkg::*;

  logic  phase_q;
  rate_e eff_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      eff_q   <= RATE_STD;
    end else begin
      phase_q <= ~phase_q;
      // apply a pending rate only once the phase pair is complete
      if (phase_q) begin
        eff_q <= rate_req;
      end
    end
  end

  assign phase    = phase_q;
  assign rate_eff = eff_q;
  assign int_tick = (eff_q == RATE_FAST) || phase_q;
endmodule

// File: rtl/drt_state_seq.sv
module drt_state_seq #(
  parameter int STATES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic int_tick,
  output logic state_tick,
  output logic periph_tick,
  output logic mcycle_strobe
);
  localparam int CNT_W = (STATES > 1) ? $clog2(STATES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STATES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;
  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (int_tick) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_tick    <= 1'b0;
      periph_tick   <= 1'b0;
      mcycle_strobe <= 1'b0;
    end else begin
      state_tick    <= int_tick;
      periph_tick   <= int_tick;
      mcycle_strobe <= int_tick && at_last;
    end
  end
endmodule

// File: rtl/dual_rate_timebase.sv
module dual_rate_timebase #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h8F,
  parameter int                SEL_BIT   = 0,
  parameter int                STATES    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              sfr_we,
  output logic [DATA_W-1:0] sfr_rdata,
  output logic              state_tick,
  output logic              periph_tick,
  output logic              mcycle_strobe
);
  import drt_pkg::*;

  rate_e rate_req;
  rate_e rate_eff;
  logic  phase;
  logic  int_tick;

  drt_ctrl_sfr #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .SEL_BIT(SEL_BIT)
  ) u_sfr (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .rate_req(rate_req)
  );

  drt_rate_phase u_phase (
    .clk(clk), .rst(rst), .rate_req(rate_req), .phase(phase),
    .rate_eff(rate_eff), .int_tick(int_tick)
  );

  drt_state_seq #(.STATES(STATES)) u_seq (
    .clk(clk), .rst(rst), .int_tick(int_tick), .state_tick(state_tick),
    .periph_tick(periph_tick), .mcycle_strobe(mcycle_strobe)
  );
endmodule

// File: rtl/drt_checker.sv
module drt_checker #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h8F,
  parameter int                SEL_BIT   = 0,
  parameter int                STATES    = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic [DATA_W-1:0] sfr_rdata,
  input logic              state_tick,
  input logic              periph_tick,
  input logic              mcycle_strobe,
  input logic              phase,
  input logic              rate_eff
);
  localparam int TW = $clog2(STATES + 1);
  logic [TW-1:0] ticks_since;

  always_ff @(posedge clk) begin
    if (rst) begin
      ticks_since <= '0;
    end else if (state_tick) begin
      ticks_since <= mcycle_strobe ? '0 : ticks_since + 1'b1;
    end
  end

  // R2: enables are low on the cycle after reset
  a_r2_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!state_tick && !mcycle_strobe && !periph_tick));

  // R5: strobe only together with a tick
  a_r5_strobe_on_tick: assert property (@(posedge clk) disable iff (rst)
    mcycle_strobe |-> state_tick);

  // R5: strobe lands on the sixth tick
  a_r5_sixth_tick: assert property (@(posedge clk) disable iff (rst)
    mcycle_strobe |-> (ticks_since == TW'(STATES - 1)));

  // R6: peripheral tick mirrors state tick
  a_r6_periph_same: assert property (@(posedge clk) disable iff (rst)
    periph_tick == state_tick);

  // R7: reserved bits read zero
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (sfr_rdata & ~(DATA_W'(1) << SEL_BIT)) == '0);

  // R8: foreign address reads zero
  a_r8_foreign_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(sfr_addr) != CTRL_ADDR) |-> (sfr_rdata == '0));

  // R9: effective rate changes only after the odd phase
  a_r9_switch_boundary: assert property (@(posedge clk) disable iff (rst)
    !$stable(rate_eff) |-> $past(phase));

  // R9: at standard rate no two ticks in a row
  a_r9_no_double_std: assert property (@(posedge clk) disable iff (rst)
    (state_tick && $past(state_tick) && !$past(rst)) |-> ($past(rate_eff, 2) || $past(rate_eff)));
endmodule

bind dual_rate_timebase drt_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
  .SEL_BIT(SEL_BIT), .STATES(STATES)
) u_chk (
  .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_rdata(sfr_rdata),
  .state_tick(state_tick), .periph_tick(periph_tick),
  .mcycle_strobe(mcycle_strobe), .phase(phase), .rate_eff(rate_eff)
);

// File: tb/tb_dual_rate_timebase.sv
module tb_dual_rate_timebase;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CTRL = 8'h8F;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sfr_addr = '0;
  logic [7:0] sfr_wdata = '0;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_rdata;
  logic       state_tick, periph_tick, mcycle_strobe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_rate_timebase dut (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .state_tick(state_tick),
    .periph_tick(periph_tick), .mcycle_strobe(mcycle_strobe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    sfr_addr = a;
    @(negedge clk);
    d = sfr_rdata;
  endtask

  task automatic measure(input int n, output int ticks, output int strobes);
    ticks = 0; strobes = 0;
    repeat (n) begin
      @(negedge clk);
      if (state_tick) ticks++;
      if (mcycle_strobe) strobes++;
    end
  endtask

  // continuous monitor: tick spacing, six ticks per strobe, peripheral match
  int cyc = 0, last_tick = -1, tick_cnt = 0;
  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; last_tick = -1; tick_cnt = 0;
    end else begin
      cyc++;
      if (periph_tick != state_tick) check("R6 periph_tick", periph_tick, state_tick);
      if (state_tick) begin
        if (last_tick >= 0 && (cyc - last_tick) > 2)
          check("R9 tick spacing", cyc - last_tick, 2);
        last_tick = cyc;
        tick_cnt++;
      end
      if (mcycle_strobe) begin
        check("R5 ticks per machine cycle", tick_cnt, 6);
        check("R5 strobe with tick", state_tick, 1);
        tick_cnt = 0;
      end
    end
  end

  initial begin
    logic [7:0] rd;
    int t, s;
    // R2: outputs quiet during reset
    repeat (3) @(negedge clk);
    check("R2 tick in reset", state_tick, 0);
    check("R2 strobe in reset", mcycle_strobe, 0);
    check("R2 rdata in reset", sfr_rdata, 0);
    rst = 1'b0;
    sfr_read(CTRL, rd);
    check("R2 mode after reset", rd, 0);
    measure(24, t, s);
    check("R3 std ticks/24", t, 12);
    check("R5 std strobes/24", s, 2);

    // R8: write elsewhere has no effect
    sfr_write(8'h8E, 8'h01);
    sfr_write(8'h0F, 8'hFF);
    sfr_read(CTRL, rd);
    check("R8 foreign write kept reg", rd, 0);
    repeat (4) @(negedge clk);
    measure(24, t, s);
    check("R8 foreign write kept rate", t, 12);

    // R1/R7: reserved bits ignored, switch to double rate
    sfr_write(CTRL, 8'hFF);
    sfr_read(CTRL, rd);
    check("R7 reserved read zero", rd, 1);
    repeat (2) @(negedge clk);
    measure(24, t, s);
    check("R4 fast ticks/24", t, 24);
    check("R5 fast strobes/24", s, 4);

    // R8: address sweep
    for (int a = 0; a < 256; a++) begin
      sfr_read(8'(a), rd);
      check("R8 addr sweep", rd, (a == 8'h8F) ? 1 : 0);
    end

    // R1/R7: data sweep
    for (int d = 0; d < 256; d++) begin
      sfr_write(CTRL, 8'(d));
      sfr_read(CTRL, rd);
      check("R1 data sweep", rd, d & 1);
    end

    // R10: slow again, settled within 3 edges of the write
    @(negedge clk);
    sfr_addr = CTRL; sfr_wdata = 8'h00; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0;
    repeat (2) @(negedge clk);
    measure(24, t, s);
    check("R10 back to std ticks/24", t, 12);
    check("R10 back to std strobes/24", s, 2);

    // R10: fast again with exact latency window
    @(negedge clk);
    sfr_addr = CTRL; sfr_wdata = 8'h01; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0;
    repeat (2) @(negedge clk);
    measure(12, t, s);
    check("R10 to fast ticks/12", t, 12);

    // R9: rapid toggling with varied gaps, monitor checks spacing
    for (int g = 0; g < 40; g++) begin
      sfr_write(CTRL, 8'(g & 1));
      repeat (g % 5) @(negedge clk);
    end
    sfr_write(CTRL, 8'h00);
    repeat (30) @(negedge clk);

    // R2: reset during double rate
    sfr_write(CTRL, 8'h01);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    sfr_read(CTRL, rd);
    check("R2 mode cleared by reset", rd, 0);
    measure(24, t, s);
    check("R2 std after reset ticks/24", t, 12);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule